// File: doc/BRIEF.md
# Asynchronous Serial Channel with Status Flags

This block is a single full-duplex asynchronous serial channel. A host drives it through a small byte-wide register file with five registers: mode, control, status, transmit data and receive data. A separate baud generator supplies a 16x oversampling tick. The block turns one byte written by the host into a framed serial character on the transmit line. It also recovers characters from the receive line, using a majority vote in the middle of each bit.

Every receive and transmit event is recorded as a sticky flag in the status register. Software clears a flag by writing 0 to its position. Writing 1 leaves the flag as it is, so one register write can clear a single flag without disturbing the others. An optional multiprocessor mode adds an address/data bit to each frame. With its filter enabled, the receiver discards data frames until an address frame arrives.

Top module: `uart_ch`

## Requirements
- R1: After reset the status register (offset 2) reads 0x84, the receive data register reads 0x00, the transmit line is high and all four interrupt outputs are low. The register offsets are: 0 mode, 1 control, 2 status, 3 transmit data, 4 receive data.
- R2: The transmitted frame is built as follows. It starts with one low start bit. Then come the data bits, LSB first: 7 of them when mode bit 6 is set, 8 otherwise. Next comes an optional extra bit. In multiprocessor mode (mode bit 2) this is status bit 0 captured at frame start. Otherwise, with parity enabled (mode bit 5), it is a parity bit that gives odd total ones when mode bit 4 is set and even total ones when it is clear. The frame ends with one high stop bit, or two when mode bit 3 is set. Every bit lasts 16 ticks.
- R3: The transmitter takes a byte only when control bit 5 (transmit enable) is set and status bit 7 (tx_empty) is 0. Taking the byte sets tx_empty. While transmit enable is clear the line stays high and tx_empty stays 0.
- R4: Status bit 2 (tx_done) sets when the last stop bit ends while tx_empty is set. It clears whenever tx_empty is cleared.
- R5: With control bit 4 (receive enable) set, a received frame loads the receive data register (bit 7 forced to 0 in 7-bit mode) and sets status bit 6 (rx_full). The flags are set in the middle of the first stop bit.
- R6: Each bit is the majority of three samples taken at ticks 7, 8 and 9 of its 16. A low pulse that has ended by the middle of the start bit starts no reception. A single-tick glitch inside a bit does not change the received value.
- R7: When parity is enabled and multiprocessor mode is off, a received parity bit that does not match the selected sense sets status bit 3 (parity_err) together with rx_full.
- R8: A first stop bit that votes low sets status bit 4 (frame_err) together with rx_full.
- R9: A frame that completes while rx_full is set sets status bit 5 (overrun). The receive data register keeps its previous byte.
- R10: Status bits 7..3 are cleared by writing 0 and kept by writing 1. Bits 2 and 1 ignore writes. Bit 0 takes the written value.
- R11: In multiprocessor mode, status bit 1 (mp_rx) takes the received extra bit of each accepted frame. With control bit 3 (address filter) set, frames whose extra bit is 0 are dropped without touching any flag or data.
- R12: The interrupt outputs are: irq_txe_o = control bit 7 & tx_empty; irq_rxf_o = control bit 6 & rx_full; irq_err_o = control bit 6 & (overrun | frame_err | parity_err); irq_txd_o = control bit 2 & tx_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 16x oversampling strobe |
| addr_i | input | 3 | Register offset |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_txe_o | output | 1 | Transmit-empty interrupt |
| irq_rxf_o | output | 1 | Receive-full interrupt |
| irq_err_o | output | 1 | Receive-error interrupt |
| irq_txd_o | output | 1 | Transmit-done interrupt |

## Verification
The assertions assume the following about the inputs:
- tick_i is a single-cycle pulse with at least three clocks between pulses, so that a change on rxd_i passes the two-flop synchronizer before the next tick.
- The host does not write the mode register while a frame is in flight.

The stimulus keeps within these limits:
- The tick arrives every fourth clock.
- Receive line changes are made just after a tick.
- The mode is rewritten only while both directions are idle.
- Majority voting is exercised by a one-tick inversion placed in the middle of a bit.

// File: rtl/uart_ch_pkg.sv
package uart_ch_pkg;
  typedef struct packed {
    logic       sync_mode;
    logic       len7;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
    logic       mp_en;
    logic [1:0] clk_sel;
  } mode_t;

  typedef struct packed {
    logic       ie_empty;
    logic       ie_rx;
    logic       tx_en;
    logic       rx_en;
    logic       mp_filt;
    logic       ie_done;
    logic [1:0] clk_en;
  } ctrl_t;

  localparam int unsigned A_MODE = 0;
  localparam int unsigned A_CTRL = 1;
  localparam int unsigned A_STAT = 2;
  localparam int unsigned A_TXD  = 3;
  localparam int unsigned A_RXD  = 4;
endpackage

// File: rtl/uart_ch_tx.sv
module uart_ch_tx #(
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  logic       len7_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       stop2_i,
  input  logic       mp_en_i,
  input  logic       mpb_i,
  output logic       take_o,
  output logic       end_o,
  output logic       txd_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned FW = 12;

  logic          busy_q;
  logic [FW-1:0] sh_q, frame;
  logic [3:0]    left_q, nb;
  logic [CW-1:0] cnt_q;
  logic [7:0]    dm;
  logic          last_tick;

  always_comb begin
    int p;
    int nd;
    nd    = len7_i ? 7 : 8;
    dm    = len7_i ? {1'b0, data_i[6:0]} : data_i;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < nd) frame[1+i] = dm[i];
    end
    p = 1 + nd;
    if (mp_en_i) begin
      frame[p] = mpb_i;
      p = p + 1;
    end else if (par_en_i) begin
      frame[p] = (^dm) ^ par_odd_i;
      p = p + 1;
    end
    nb = 4'(p + (stop2_i ? 2 : 1));
  end

  assign take_o    = !busy_q && tick_i && start_i;
  assign last_tick = busy_q && tick_i && (cnt_q == CW'(OVS-1));
  assign end_o     = last_tick && (left_q == 4'd1);
  assign txd_o     = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
    end else if (take_o) begin
      busy_q <= 1'b1;
      sh_q   <= frame;
      left_q <= nb;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (last_tick) begin
        cnt_q  <= '0;
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        left_q <= left_q - 4'd1;
        if (left_q == 4'd1) busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  txd_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i |=> $stable(txd_o));
endmodule

// File: rtl/uart_ch_rx.sv
module uart_ch_rx #(
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       rxd_i,
  input  logic       len7_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       mp_en_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       mpb_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] S0 = CW'(OVS/2 - 1);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e           st_q;
  logic [1:0]    sync_q;
  logic          rx_s, s_a, s_b, ext_q, vote, vote_tick;
  logic [CW-1:0] cnt_q;
  logic [3:0]    pos_q, nd, stop_pos;
  logic [7:0]    sh_q;

  assign rx_s      = sync_q[1];
  assign vote      = (s_a & s_b) | (s_a & rx_s) | (s_b & rx_s);
  assign nd        = len7_i ? 4'd7 : 4'd8;
  assign stop_pos  = 4'd1 + nd + {3'b0, (mp_en_i | par_en_i)};
  assign vote_tick = (st_q == ST_RUN) && tick_i && (cnt_q == S0 + CW'(2));
  assign done_o    = vote_tick && (pos_q == stop_pos);
  assign data_o    = len7_i ? {1'b0, sh_q[7:1]} : sh_q;
  assign ferr_o    = !vote;
  assign perr_o    = par_en_i && !mp_en_i && (((^data_o) ^ ext_q) != par_odd_i);
  assign mpb_o     = ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pos_q  <= '0;
      s_a    <= 1'b1;
      s_b    <= 1'b1;
      ext_q  <= 1'b0;
      sh_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (!en_i) begin
        st_q <= ST_IDLE;
      end else if (st_q == ST_IDLE) begin
        if (tick_i && !rx_s) begin
          st_q  <= ST_RUN;
          cnt_q <= '0;
          pos_q <= '0;
        end
      end else if (tick_i) begin
        cnt_q <= (cnt_q == CW'(OVS-1)) ? '0 : cnt_q + 1'b1;
        if (cnt_q == CW'(OVS-1)) pos_q <= pos_q + 4'd1;
        if (cnt_q == S0) s_a <= rx_s;
        if (cnt_q == S0 + CW'(1)) s_b <= rx_s;
        if (vote_tick) begin
          if (pos_q == 4'd0) begin
            if (vote) st_q <= ST_IDLE;
          end else if (pos_q <= nd) begin
            sh_q <= {vote, sh_q[7:1]};
          end else if (pos_q == stop_pos) begin
            st_q <= ST_IDLE;
          end else begin
            ext_q <= vote;
          end
        end
      end
    end
  end

  // R6
  start_confirm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) && (pos_q == 4'd0) && vote_tick && vote |=> (st_q == ST_IDLE));
endmodule

// File: rtl/uart_ch.sv
module uart_ch
  import uart_ch_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              irq_txe_o,
  output logic              irq_rxf_o,
  output logic              irq_err_o,
  output logic              irq_txd_o
);
  mode_t      mode_q;
  ctrl_t      ctrl_q;
  logic [7:0] tdr_q, rdr_q;
  logic       empty_q, full_q, ovr_q, ferr_q, perr_q, done_q, mprx_q, mptx_q;
  logic       tx_take, tx_end, rx_done, rx_perr, rx_ferr, rx_mpb, accept;
  logic [7:0] rx_data;
  logic       wr_stat;

  assign wr_stat = we_i && (addr_i == ADDR_W'(A_STAT));
  assign accept  = rx_done && ctrl_q.rx_en &&
                   !(mode_q.mp_en && ctrl_q.mp_filt && !rx_mpb);

  uart_ch_tx #(.OVS(OVS)) u_tx (
    .clk_i, .rst_ni, .tick_i,
    .start_i  (ctrl_q.tx_en && !empty_q),
    .data_i   (tdr_q),
    .len7_i   (mode_q.len7),
    .par_en_i (mode_q.par_en),
    .par_odd_i(mode_q.par_odd),
    .stop2_i  (mode_q.stop2),
    .mp_en_i  (mode_q.mp_en),
    .mpb_i    (mptx_q),
    .take_o   (tx_take),
    .end_o    (tx_end),
    .txd_o
  );

  uart_ch_rx #(.OVS(OVS)) u_rx (
    .clk_i, .rst_ni, .tick_i,
    .en_i     (ctrl_q.rx_en),
    .rxd_i,
    .len7_i   (mode_q.len7),
    .par_en_i (mode_q.par_en),
    .par_odd_i(mode_q.par_odd),
    .mp_en_i  (mode_q.mp_en),
    .done_o   (rx_done),
    .data_o   (rx_data),
    .perr_o   (rx_perr),
    .ferr_o   (rx_ferr),
    .mpb_o    (rx_mpb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      ctrl_q  <= '0;
      tdr_q   <= '0;
      rdr_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
      done_q  <= 1'b1;
      mprx_q  <= 1'b0;
      mptx_q  <= 1'b0;
    end else begin
      if (we_i && addr_i == ADDR_W'(A_MODE)) mode_q <= mode_t'(wdata_i);
      if (we_i && addr_i == ADDR_W'(A_CTRL)) ctrl_q <= ctrl_t'(wdata_i);
      if (we_i && addr_i == ADDR_W'(A_TXD))  tdr_q  <= wdata_i;
      // write 0 clears, write 1 keeps
      if (wr_stat) begin
        empty_q <= empty_q & wdata_i[7];
        full_q  <= full_q  & wdata_i[6];
        ovr_q   <= ovr_q   & wdata_i[5];
        ferr_q  <= ferr_q  & wdata_i[4];
        perr_q  <= perr_q  & wdata_i[3];
        if (!wdata_i[7]) done_q <= 1'b0;
        mptx_q  <= wdata_i[0];
      end
      if (tx_take) empty_q <= 1'b1;
      if (tx_end && empty_q) done_q <= 1'b1;
      if (accept) begin
        if (full_q) begin
          ovr_q <= 1'b1;
        end else begin
          full_q <= 1'b1;
          rdr_q  <= rx_data;
          if (rx_ferr) ferr_q <= 1'b1;
          if (rx_perr) perr_q <= 1'b1;
          if (mode_q.mp_en) mprx_q <= rx_mpb;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_MODE): rdata_o = mode_q;
      ADDR_W'(A_CTRL): rdata_o = ctrl_q;
      ADDR_W'(A_STAT): rdata_o = {empty_q, full_q, ovr_q, ferr_q, perr_q, done_q, mprx_q, mptx_q};
      ADDR_W'(A_TXD):  rdata_o = tdr_q;
      ADDR_W'(A_RXD):  rdata_o = rdr_q;
      default:         rdata_o = '0;
    endcase
  end

  assign irq_txe_o = ctrl_q.ie_empty & empty_q;
  assign irq_rxf_o = ctrl_q.ie_rx & full_q;
  assign irq_err_o = ctrl_q.ie_rx & (ovr_q | ferr_q | perr_q);
  assign irq_txd_o = ctrl_q.ie_done & done_q;

  // R3
  take_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take |-> !empty_q && ctrl_q.tx_en);
  // R4
  done_needs_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> empty_q);
  // R9
  overrun_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $stable(rdr_q));
  // R5
  full_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(rx_done && ctrl_q.rx_en));
endmodule

// File: tb/uart_ch_tb.sv
module uart_ch_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tcnt;
  logic       tick;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rxd_drv = 1'b1;
  logic       loop = 1'b0;
  logic       rxd, txd;
  logic       irq_txe, irq_rxf, irq_err, irq_txd;
  int         vectors = 0;
  int         fails = 0;
  int         cycles = 0;
  logic       exp_mpb = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0; else tcnt <= tcnt + 2'd1;
  assign tick = (tcnt == 2'd3);
  assign rxd  = loop ? txd : rxd_drv;

  uart_ch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd),
    .irq_txe_o(irq_txe), .irq_rxf_o(irq_rxf), .irq_err_o(irq_err), .irq_txd_o(irq_txd)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<190000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string req);
    vectors = vectors + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
    @(posedge clk); #1;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  // c = {len7, par_en, par_odd, stop2, mp_en}
  function automatic logic [11:0] mkframe(input logic [4:0] c, input logic [7:0] d,
                                          input logic mb, output int n);
    logic [11:0] f;
    logic [7:0]  dm;
    int nd, p;
    nd = c[4] ? 7 : 8;
    dm = c[4] ? (d & 8'h7f) : d;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[1+i] = dm[i];
    p = 1 + nd;
    if (c[0]) begin f[p] = mb; p = p + 1; end
    else if (c[3]) begin f[p] = (^dm) ^ c[2]; p = p + 1; end
    n = p + (c[1] ? 2 : 1);
    return f;
  endfunction

  task automatic rx_send(input logic [11:0] f, input int n, input int gbit);
    wait_tick();
    for (int i = 0; i < n; i++) begin
      rxd_drv = f[i];
      if (i == gbit) begin
        wait_ticks(8); rxd_drv = ~f[i]; wait_tick(); rxd_drv = f[i]; wait_ticks(7);
      end else begin
        wait_ticks(16);
      end
    end
    rxd_drv = 1'b1;
    wait_ticks(4);
  endtask

  initial begin
    logic [7:0]  v;
    logic [11:0] f, got;
    int          n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, v); chk({4'd0, v}, 12'h084, "R1 status");
    rd(3'd4, v); chk({4'd0, v}, 12'h000, "R1 rxdata");
    chk({8'd0, txd, irq_txe, irq_rxf, irq_err}, 12'h008, "R1 line/irq");
    chk({11'd0, irq_txd}, 12'h000, "R1 irq_txd");

    wr(3'd1, 8'h10);
    // R6 glitch in data bit 3 is voted away
    f = mkframe(5'b00000, 8'h5a, 1'b0, n);
    rx_send(f, n, 4);
    rd(3'd2, v); chk({4'd0, v}, 12'h0c4, "R6 glitch status");
    rd(3'd4, v); chk({4'd0, v}, 12'h05a, "R6 glitch data");
    wr(3'd2, 8'hb8);
    // R6 short low pulse starts nothing
    wait_tick(); rxd_drv = 1'b0; wait_ticks(4); rxd_drv = 1'b1; wait_ticks(30);
    rd(3'd2, v); chk({4'd0, v}, 12'h084, "R6 false start");
    // R5 normal reception
    f = mkframe(5'b00000, 8'h3c, 1'b0, n);
    rx_send(f, n, -1);
    rd(3'd2, v); chk({4'd0, v}, 12'h0c4, "R5 status");
    rd(3'd4, v); chk({4'd0, v}, 12'h03c, "R5 data");
    // R9 overrun keeps old byte
    f = mkframe(5'b00000, 8'hc3, 1'b0, n);
    rx_send(f, n, -1);
    rd(3'd2, v); chk({4'd0, v}, 12'h0e4, "R9 status");
    rd(3'd4, v); chk({4'd0, v}, 12'h03c, "R9 data");
    // R10 write-one keeps, write-zero clears, read-only bits
    wr(3'd2, 8'hff); rd(3'd2, v); chk({4'd0, v}, 12'h0e5, "R10 keep");
    wr(3'd2, 8'hdf); rd(3'd2, v); chk({4'd0, v}, 12'h0c5, "R10 clear one");
    wr(3'd2, 8'h06); rd(3'd2, v); chk({4'd0, v}, 12'h000, "R10 read-only");
    // R3 no transmission without enable
    wait_ticks(40);
    rd(3'd2, v); chk({4'd0, v}, 12'h000, "R3 idle empty");
    chk({11'd0, txd}, 12'h001, "R3 line high");
    // R3 R4 enable starts a frame; done afterwards
    wr(3'd1, 8'h30);
    wait_ticks(200);
    rd(3'd2, v); chk({4'd0, v}, 12'h084, "R4 after frame");

    // R7 parity error (even parity, bit flipped)
    wr(3'd1, 8'h10); wr(3'd0, 8'h20);
    f = mkframe(5'b01000, 8'h5a, 1'b0, n); f[9] = ~f[9];
    rx_send(f, n, -1);
    rd(3'd2, v); chk({4'd0, v}, 12'h0cc, "R7 status");
    rd(3'd4, v); chk({4'd0, v}, 12'h05a, "R7 data");
    wr(3'd2, 8'hb0);
    // R8 framing error
    wr(3'd0, 8'h00);
    f = mkframe(5'b00000, 8'h81, 1'b0, n); f[9] = 1'b0;
    rx_send(f, n, -1);
    wait_ticks(20);
    rd(3'd2, v); chk({4'd0, v}, 12'h0d4, "R8 status");
    rd(3'd4, v); chk({4'd0, v}, 12'h081, "R8 data");
    wr(3'd2, 8'ha8);

    // R11 multiprocessor filter
    wr(3'd0, 8'h04); wr(3'd1, 8'h18);
    f = mkframe(5'b00001, 8'h11, 1'b0, n);
    rx_send(f, n, -1);
    rd(3'd2, v); chk({4'd0, v}, 12'h084, "R11 data frame dropped");
    f = mkframe(5'b00001, 8'h22, 1'b1, n);
    rx_send(f, n, -1);
    rd(3'd2, v); chk({4'd0, v}, 12'h0c6, "R11 address frame");
    rd(3'd4, v); chk({4'd0, v}, 12'h022, "R11 data");

    // R12 interrupts
    wr(3'd1, 8'hc4); @(negedge clk);
    chk({8'd0, irq_txe, irq_rxf, irq_err, irq_txd}, 12'h00d, "R12 irq set A");
    wr(3'd1, 8'hdc);
    f = mkframe(5'b00001, 8'h33, 1'b1, n);
    rx_send(f, n, -1);
    chk({8'd0, irq_txe, irq_rxf, irq_err, irq_txd}, 12'h00f, "R12 irq err");
    rd(3'd2, v); chk({4'd0, v}, 12'h0e6, "R9 mp overrun");
    rd(3'd4, v); chk({4'd0, v}, 12'h022, "R9 mp data kept");
    wr(3'd1, 8'h00); @(negedge clk);
    chk({8'd0, irq_txe, irq_rxf, irq_err, irq_txd}, 12'h000, "R12 irq masked");
    wr(3'd2, 8'h80);
    exp_mpb = 1'b1;

    // R2 R5 R7 sweep over all frame modes with loopback
    loop = 1'b1;
    wr(3'd1, 8'h30);
    for (int c = 0; c < 32; c++) begin
      wr(3'd0, {1'b0, c[4:0], 2'b00});
      for (int k = 0; k < 2; k++) begin
        logic [7:0] d;
        logic       mb;
        logic [7:0] ev;
        int         nb;
        d  = 8'(c * 37 + k * 101 + 5);
        mb = k[0] ^ c[0];
        f  = mkframe(c[4:0], d, mb, nb);
        wr(3'd3, d);
        wr(3'd2, 8'h78 | {7'd0, mb});
        while (txd) @(negedge clk);
        rd(3'd2, v); chk({11'd0, v[7]}, 12'h001, "R3 empty on take");
        got = '1;
        wait_ticks(8);
        for (int i = 0; i < nb; i++) begin
          got[i] = txd;
          if (i < nb - 1) wait_ticks(16);
        end
        chk(got, f, "R2 frame");
        wait_ticks(16);
        if (c[0]) exp_mpb = mb;
        ev = {6'b110001, exp_mpb, mb} | 8'h04;
        rd(3'd2, v); chk({4'd0, v}, {4'd0, ev}, "R4 R5 status");
        rd(3'd4, v); chk({4'd0, v}, {4'd0, (c[4] ? (d & 8'h7f) : d)}, "R5 loop data");
        wr(3'd2, 8'hb8 | {7'd0, mb});
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule